// File: doc/BRIEF.md
# Edge-Selectable Event Counter Bank

A bank of three 32-bit counters. Each counter has its own mode: as a timer it steps once on every clock, and as an event counter it steps only on the input edges chosen for it. There are three external event pins. Each pin passes through a two-flop synchroniser and then a small level-tracking state machine. That machine emits a one-cycle rise or fall pulse. A per-counter block of six enable bits selects which of these pulses may advance the counter.

The enable bits and the mode bits cannot be written at their main addresses. Software changes them through a write-ones-to-set alias and a write-ones-to-clear alias, so bits owned by one counter can be changed without disturbing bits owned by another. The counters can be read and loaded over a simple single-cycle register bus. Read data is combinational from the current register state.

Each pin's edge tracker is a two-state machine:
- `LVL_LOW`: the last seen synchronised level was 0. The transition `LVL_LOW -> LVL_HIGH` is taken when the synchronised level is 1, and it emits a rise pulse in that cycle.
- `LVL_HIGH`: the last seen synchronised level was 1. The transition `LVL_HIGH -> LVL_LOW` is taken when the synchronised level is 0, and it emits a fall pulse in that cycle.
- Each state holds when the level is unchanged.

Address map (word addresses):

| Address | Access | Contents |
|---|---|---|
| 0 | read | edge enables |
| 1 | write | set alias for the edge enables |
| 2 | write | clear alias for the edge enables |
| 3 | read | modes |
| 4 | write | set alias for the modes |
| 5 | write | clear alias for the modes |
| 6, 7, 8 | read/write | counters 0, 1, 2 |

Top module: `evc_counter_bank`

## Requirements
- R1: After reset, the edge-enable register, the mode register and all three counters read 0.
- R2: A counter whose mode bit is 0 (timer) advances by one on every clock. Its edge enables have no effect on it.
- R3: A counter whose mode bit is 1 advances only on enabled edges. Counter k owns enable bits 6k to 6k+5: bit 6k+2i enables the rising edge of pin i, and bit 6k+2i+1 enables the falling edge of pin i. The mode bit for counter k is mode bit k.
- R4: An edge whose enable bit is 0 leaves an event-mode counter unchanged, and with no edges the counter holds its value.
- R5: When several enabled edges reach one counter in the same clock cycle, that counter advances by exactly one.
- R6: Writing to address 1 (enables) or address 4 (modes) sets each bit written as 1. Bits written as 0 keep their value.
- R7: Writing to address 2 (enables) or address 5 (modes) clears each bit written as 1. Bits written as 0 keep their value.
- R8: Writes to addresses 0 and 3 have no effect. Alias addresses read as 0.
- R9: A write to address 6+k loads counter k, and the new value is read back on the next cycle. A load takes priority over an increment in the same cycle.
- R10: A counter wraps from 0xFFFFFFFF to 0.
- R11: A pin change applied between clock edges shows in an event-mode counter after the third following clock edge and not after the second. A held level causes only one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer-mode count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 3 | Asynchronous event pins |
| bus_addr | input | 4 | Register word address |
| bus_wen | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |

## Verification
Two things can fall in the same clock edge. The first is a bus load of a counter together with an increment of that counter. This is provoked by loading a timer-mode counter, which steps on every edge, and by loading 0xFFFFFFFF. The read-back must show exactly the loaded value, and the wrap to 0 must appear one edge later. The second is two enabled edges on different pins at once: one rise and one fall are driven in a single input change, and the counter must step by one, not two.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int unsigned ADR_EN       = 0;
    localparam int unsigned ADR_EN_SET   = 1;
    localparam int unsigned ADR_EN_CLR   = 2;
    localparam int unsigned ADR_MODE     = 3;
    localparam int unsigned ADR_MODE_SET = 4;
    localparam int unsigned ADR_MODE_CLR = 5;
    localparam int unsigned ADR_CNT_BASE = 6;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MODE_SET,
        OP_MODE_CLR
    } bus_op_e;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } lvl_state_e;

endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    import evc_pkg::*;

    logic       meta_q;
    logic       sync_q;
    lvl_state_e state_q;
    lvl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (sync_q)  state_d = LVL_HIGH;
            LVL_HIGH: if (!sync_q) state_d = LVL_LOW;
            default:  state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = sync_q;
            LVL_HIGH: fall = !sync_q;
            default:  ;
        endcase
    end

    // R11: a held level yields a single pulse
    a_r11_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r11_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
    a_r11_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

endmodule

// File: rtl/evc_ctrl_regs.sv
module evc_ctrl_regs #(
    parameter int unsigned NUM_CNT = 3,
    parameter int unsigned NUM_IN  = 3,
    parameter int unsigned ADDR_W  = 4,
    localparam int unsigned CTRL_W = NUM_CNT * 2 * NUM_IN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wen,
    input  logic [CTRL_W-1:0]  set_data,
    output logic [CTRL_W-1:0]  edge_en,
    output logic [NUM_CNT-1:0] cnt_mode,
    output logic [NUM_CNT-1:0] cnt_load,
    output logic [CTRL_W-1:0]  en_view,
    output logic [NUM_CNT-1:0] mode_view
);
    import evc_pkg::*;

    localparam logic [ADDR_W-1:0] A_EN       = ADDR_W'(ADR_EN);
    localparam logic [ADDR_W-1:0] A_EN_SET   = ADDR_W'(ADR_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR   = ADDR_W'(ADR_EN_CLR);
    localparam logic [ADDR_W-1:0] A_MODE     = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_MODE_SET = ADDR_W'(ADR_MODE_SET);
    localparam logic [ADDR_W-1:0] A_MODE_CLR = ADDR_W'(ADR_MODE_CLR);

    bus_op_e           op;
    logic [CTRL_W-1:0] en_q;
    logic [NUM_CNT-1:0] mode_q;
    logic [NUM_CNT-1:0] mode_bits;

    assign mode_bits = set_data[NUM_CNT-1:0];

    always_comb begin
        op = OP_IDLE;
        if (bus_wen) begin
            if      (bus_addr == A_EN_SET)   op = OP_EN_SET;
            else if (bus_addr == A_EN_CLR)   op = OP_EN_CLR;
            else if (bus_addr == A_MODE_SET) op = OP_MODE_SET;
            else if (bus_addr == A_MODE_CLR) op = OP_MODE_CLR;
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_load
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADR_CNT_BASE + k);
        assign cnt_load[k] = bus_wen && (bus_addr == A_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
        end else begin
            unique case (op)
                OP_EN_SET:   en_q   <= en_q | set_data;
                OP_EN_CLR:   en_q   <= en_q & ~set_data;
                OP_MODE_SET: mode_q <= mode_q | mode_bits;
                OP_MODE_CLR: mode_q <= mode_q & ~mode_bits;
                default:     ;
            endcase
        end
    end

    assign edge_en   = en_q;
    assign cnt_mode  = mode_q;
    assign en_view   = (bus_addr == A_EN)   ? en_q   : '0;
    assign mode_view = (bus_addr == A_MODE) ? mode_q : '0;

    // R6: every bit written as one is set afterwards, others untouched
    a_r6_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == A_EN_SET) |=>
            ((en_q & $past(set_data)) == $past(set_data)) &&
            ((en_q & ~$past(set_data)) == ($past(en_q) & ~$past(set_data))));
    // R7: every bit written as one is cleared afterwards
    a_r7_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == A_EN_CLR) |=>
            ((en_q & $past(set_data)) == '0) &&
            ((en_q & ~$past(set_data)) == ($past(en_q) & ~$past(set_data))));
    a_r7_mode_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == A_MODE_CLR) |=> ((mode_q & $past(mode_bits)) == '0));
    // R8: main addresses are read-only
    a_r8_en_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && (bus_addr == A_EN || bus_addr == A_MODE)) |=>
            ($stable(en_q) && $stable(mode_q)));
    // R9: at most one counter is loaded per cycle
    a_r9_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_load));

endmodule

// File: rtl/evc_count_cell.sv
module evc_count_cell #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_IN = 3,
    localparam int unsigned EN_PER = 2 * NUM_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic [EN_PER-1:0] en_bits,
    input  logic [NUM_IN-1:0] rise,
    input  logic [NUM_IN-1:0] fall,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count
);
    logic [EN_PER-1:0] ev;
    logic              hit;
    logic              step;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_ev
        assign ev[2*i]   = rise[i];
        assign ev[2*i+1] = fall[i];
    end

    assign hit  = |(en_bits & ev);
    assign step = mode ? hit : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= count + CNT_W'(1);
    end

    // R9: a load beats an increment
    a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));
    // R2 and R10: timer mode steps every clock, wrapping
    a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !mode) |=> count == $past(count) + CNT_W'(1));
    // R4: without edges an event counter holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && mode && !(|rise) && !(|fall)) |=> $stable(count));
    // R5: never more than one step per cycle
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (count - $past(count)) <= CNT_W'(1));

endmodule

// File: rtl/evc_counter_bank.sv
module evc_counter_bank #(
    parameter int unsigned NUM_CNT = 3,
    parameter int unsigned NUM_IN  = 3,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] ext_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import evc_pkg::*;

    localparam int unsigned EN_PER = 2 * NUM_IN;
    localparam int unsigned CTRL_W = NUM_CNT * EN_PER;

    logic [NUM_IN-1:0]  rise;
    logic [NUM_IN-1:0]  fall;
    logic [CTRL_W-1:0]  edge_en;
    logic [NUM_CNT-1:0] cnt_mode;
    logic [NUM_CNT-1:0] cnt_load;
    logic [CTRL_W-1:0]  en_view;
    logic [NUM_CNT-1:0] mode_view;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
        evc_sync_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ext_in[i]),
            .rise (rise[i]),
            .fall (fall[i])
        );
    end

    evc_ctrl_regs #(
        .NUM_CNT(NUM_CNT),
        .NUM_IN (NUM_IN),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wen  (bus_wen),
        .set_data (bus_wdata[CTRL_W-1:0]),
        .edge_en  (edge_en),
        .cnt_mode (cnt_mode),
        .cnt_load (cnt_load),
        .en_view  (en_view),
        .mode_view(mode_view)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        evc_count_cell #(
            .CNT_W (CNT_W),
            .NUM_IN(NUM_IN)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (cnt_mode[k]),
            .en_bits (edge_en[k*EN_PER +: EN_PER]),
            .rise    (rise),
            .fall    (fall),
            .load    (cnt_load[k]),
            .load_val(bus_wdata[CNT_W-1:0]),
            .count   (cnt_q[k])
        );
    end

    always_comb begin
        bus_rdata = DATA_W'(en_view) | DATA_W'(mode_view);
        for (int k = 0; k < NUM_CNT; k++) begin
            if (bus_addr == ADDR_W'(ADR_CNT_BASE + k)) bus_rdata = DATA_W'(cnt_q[k]);
        end
    end

endmodule

// File: tb/evc_counter_bank_test.sv
module evc_counter_bank_test;
    localparam int CLK_PERIOD = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ext_in = 3'b000;
    logic [3:0]  bus_addr = 4'd0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    event        sample_ev;

    evc_counter_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_in),
        .bus_addr (bus_addr),
        .bus_wen  (bus_wen),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: pops expected items and compares with the design's read data
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s addr=%0d got=%h expected=%h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wen = 1'b1;
        @(posedge clk);
        #1;
        bus_wen = 1'b0;
    endtask

    // driver: pushes the expected item and hands it to the monitor
    task automatic chk(input logic [3:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        #1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> sample_ev;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 6000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state, before any edge after release
        chk(4'd0, 32'h0, "R1 enables");
        chk(4'd3, 32'h0, "R1 modes");
        chk(4'd6, 32'h0, "R1 cnt0");
        chk(4'd7, 32'h0, "R1 cnt1");
        chk(4'd8, 32'h0, "R1 cnt2");

        // R2: timer mode
        tick(4);
        chk(4'd6, 32'd4, "R2 cnt0 after 4 clocks");

        // R9: load wins over the timer step
        bus_write(4'd6, 32'd100);
        chk(4'd6, 32'd100, "R9 load priority");
        tick(7);
        chk(4'd6, 32'd107, "R2 timer after load");

        // R10: wrap
        bus_write(4'd6, 32'hFFFF_FFFF);
        chk(4'd6, 32'hFFFF_FFFF, "R10 all ones loaded");
        tick(1);
        chk(4'd6, 32'h0, "R10 wrap to zero");

        // R6 modes set, R8 read-only main addresses
        bus_write(4'd4, 32'h6);
        chk(4'd3, 32'h6, "R6 mode set");
        bus_write(4'd4, 32'h0);
        chk(4'd3, 32'h6, "R6 zeros keep modes");
        bus_write(4'd3, 32'h0);
        chk(4'd3, 32'h6, "R8 mode read-only");
        bus_write(4'd0, 32'hFFFF_FFFF);
        chk(4'd0, 32'h0, "R8 enable read-only");
        chk(4'd1, 32'h0, "R8 alias reads zero");

        bus_write(4'd7, 32'd0);
        bus_write(4'd8, 32'd0);

        // R4: no enables, edges ignored
        ext_in[0] = 1'b1; tick(4);
        ext_in[0] = 1'b0; tick(4);
        chk(4'd7, 32'd0, "R4 cnt1 no enables");
        chk(4'd8, 32'd0, "R4 cnt2 no enables");

        // R6: enable pin0 rise for counter 1 (bit 6)
        bus_write(4'd1, 32'h40);
        chk(4'd0, 32'h40, "R6 enable set");

        // R11: latency
        ext_in[0] = 1'b1;
        tick(2);
        chk(4'd7, 32'd0, "R11 not yet after two edges");
        tick(1);
        chk(4'd7, 32'd1, "R11 visible after three edges");
        tick(3);
        chk(4'd7, 32'd1, "R11 held level single step");

        // R4: disabled falling edge
        ext_in[0] = 1'b0; tick(4);
        chk(4'd7, 32'd1, "R4 pin0 fall disabled");

        // R3: pin2 fall (bit 11) and pin1 fall (bit 9)
        bus_write(4'd1, 32'hA00);
        chk(4'd0, 32'hA40, "R3 enable layout");
        ext_in[2] = 1'b1; tick(4);
        chk(4'd7, 32'd1, "R3 pin2 rise not enabled");
        ext_in[2] = 1'b0; tick(4);
        chk(4'd7, 32'd2, "R3 pin2 fall counts");

        // R5: pin0 rise and pin1 fall in one cycle
        ext_in = 3'b010; tick(4);
        chk(4'd7, 32'd2, "R3 pin1 rise not enabled");
        ext_in = 3'b001; tick(4);
        chk(4'd7, 32'd3, "R5 two edges one step");
        ext_in = 3'b000; tick(4);
        chk(4'd7, 32'd3, "R4 pin0 fall disabled again");
        chk(4'd8, 32'd0, "R4 cnt2 unaffected");

        // R7: clear pin0 rise enable
        bus_write(4'd2, 32'h40);
        chk(4'd0, 32'hA00, "R7 enable clear");
        ext_in[0] = 1'b1; tick(4);
        chk(4'd7, 32'd3, "R7 cleared enable ignored");
        ext_in[0] = 1'b0; tick(4);

        // R7: mode clear, counter 1 back to timer
        bus_write(4'd5, 32'h2);
        chk(4'd3, 32'h4, "R7 mode clear");
        chk(4'd7, 32'd3, "R7 cnt1 at mode change");
        tick(5);
        chk(4'd7, 32'd8, "R2 cnt1 timer again");

        // R9: load in event mode
        bus_write(4'd8, 32'd55);
        chk(4'd8, 32'd55, "R9 load cnt2");

        // R2: enables do not add steps in timer mode (bit 0)
        bus_write(4'd1, 32'h1);
        bus_write(4'd6, 32'd0);
        ext_in[0] = 1'b1;
        tick(6);
        chk(4'd6, 32'd6, "R2 edges no effect in timer mode");
        bus_write(4'd2, 32'h0);
        chk(4'd0, 32'hA01, "R7 zeros keep enables");

        #5;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule